// File: doc/BRIEF.md
# Fork-Join Vector Stream Pipeline

This block is a streaming datapath for wide vector beats. Each beat carries sixteen 32-bit lanes, and all sixteen lanes are worked on in the same cycle. An entry stage triples every lane. It then writes the same tripled beat into two branch FIFOs. One branch adds 25 to each lane. The other branch doubles each lane. A join stage waits until both branches hold a beat, sums the two branch words lane by lane, and places the result in an output register. The output uses a valid/ready handshake.

The stages run concurrently. A beat can leave the block while later beats are still arriving. A job begins with a start pulse that carries a beat count. The block accepts exactly that many input beats. One cycle after the last result is taken at the output, it pulses done.

Top module: `vec_diamond`

## Requirements
- R1: For every lane, the output word equals (x*3 + 25) + (x*3*2), which is 9x + 25, where x is the input word of that lane.
- R2: Arithmetic wraps modulo 2^32 inside each lane, with no carry into a neighbour lane. An input of 0xFFFFFFFF gives 0x00000010.
- R3: Lane i occupies bits [32i+31:32i] on both in_data and out_data. Lanes with different values keep their positions and stay independent.
- R4: in_ready is low while no job is running. A start pulse latches beat_count, and input is then accepted.
- R5: Once the programmed number of beats has been accepted, in_ready stays low and further input is not consumed. No extra output appears.
- R6: done is a single-cycle pulse. It appears in the cycle after the handshake of the last output beat, and busy is low in that same cycle.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. Beats leave in input order, and none is lost or repeated.
- R8: The two branch FIFOs always hold the same number of beats. With out_ready held high, in_ready stays high on every cycle of a job until the count is reached, so one beat per cycle is sustained.
- R9: A start pulse that arrives while a job is running is ignored.
- R10: A start pulse with beat_count equal to 0 accepts no input and gives done in the next cycle.
- R11: After reset, out_valid, in_ready, done and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| beat_count | input | 16 | Number of beats in the job |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when high together with in_valid |
| in_data | input | 512 | Input beat, 16 lanes of 32 bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 512 | Output beat, 16 lanes of 32 bits |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse at the end of a job |

## Verification
The bound checker checks four things on every cycle:
- the output holds steady under backpressure;
- the two branch FIFOs have equal fill levels and neither exceeds its depth;
- input is refused while idle;
- done is a single pulse that follows either a final output handshake or a start with a zero count.

Only the bench scenarios can show the following:
- the lane values themselves, including wrap-around and lane placement;
- that a job ends after exactly the programmed number of beats;
- that a start during a job is ignored;
- that the pipeline sustains one beat per cycle when nothing stalls.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int unsigned LANE_W = 32;
  typedef logic [LANE_W-1:0] lane_t;

  localparam lane_t ENTRY_MUL  = 32'd3;
  localparam lane_t OFFSET_ADD = 32'd25;
  localparam lane_t SCALE_MUL  = 32'd2;

  // Lane-mode selectors for vd_lane_map
  localparam int MAP_ENTRY  = 0;
  localparam int MAP_OFFSET = 1;
  localparam int MAP_SCALE  = 2;

  function automatic lane_t entry_op(lane_t x);
    return lane_t'(x * ENTRY_MUL);
  endfunction

  function automatic lane_t offset_op(lane_t x);
    return lane_t'(x + OFFSET_ADD);
  endfunction

  function automatic lane_t scale_op(lane_t x);
    return lane_t'(x * SCALE_MUL);
  endfunction

  function automatic lane_t merge_op(lane_t a, lane_t b);
    return lane_t'(a + b);
  endfunction
endpackage

// File: rtl/vd_fifo.sv
module vd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   din,
  output logic           full,
  input  logic           pop,
  output logic [W-1:0]   dout,
  output logic           empty,
  output logic [LVW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign full    = (level == LVW'(DEPTH));
  assign empty   = (level == '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/vd_lane_map.sv
module vd_lane_map #(
  parameter int LANES = 16,
  parameter int MODE  = 0,
  localparam int LW   = vd_pkg::LANE_W,
  localparam int DW   = LANES * LW
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  import vd_pkg::*;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (MODE == MAP_ENTRY) begin : g_entry
      assign dout[g*LW +: LW] = entry_op(din[g*LW +: LW]);
    end else if (MODE == MAP_OFFSET) begin : g_offset
      assign dout[g*LW +: LW] = offset_op(din[g*LW +: LW]);
    end else begin : g_scale
      assign dout[g*LW +: LW] = scale_op(din[g*LW +: LW]);
    end
  end
endmodule

// File: rtl/vd_lane_join.sv
module vd_lane_join #(
  parameter int LANES = 16,
  localparam int LW   = vd_pkg::LANE_W,
  localparam int DW   = LANES * LW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum
);
  import vd_pkg::*;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sum[g*LW +: LW] = merge_op(a[g*LW +: LW], b[g*LW +: LW]);
  end
endmodule

// File: rtl/vd_ctrl.sv
module vd_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             in_fire,
  input  logic             out_fire,
  output logic             busy,
  output logic             accepting,
  output logic             done
);
  logic [CNT_W-1:0] in_left, out_left;

  assign accepting = busy && (in_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      in_left  <= '0;
      out_left <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (count == '0) begin
            done <= 1'b1;
          end else begin
            busy     <= 1'b1;
            in_left  <= count;
            out_left <= count;
          end
        end
      end else begin
        if (in_fire) in_left <= in_left - 1'b1;
        if (out_fire) begin
          out_left <= out_left - 1'b1;
          if (out_left == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vec_diamond.sv
module vec_diamond #(
  parameter int LANES      = 16,
  parameter int FIFO_DEPTH = 2,
  parameter int CNT_W      = 16,
  localparam int LW        = vd_pkg::LANE_W,
  localparam int DW        = LANES * LW,
  localparam int LVW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] beat_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             busy,
  output logic             done
);
  import vd_pkg::*;

  // Named internal events, observed by the bound checker
  logic           accepting;
  logic           fork_fire, join_fire, out_fire;
  logic           full_a, full_b, empty_a, empty_b;
  logic [LVW-1:0] lvl_a, lvl_b;
  logic [DW-1:0]  tripled, head_a, head_b, br_a, br_b, merged;

  assign in_ready  = accepting && !full_a && !full_b;
  assign fork_fire = in_valid && in_ready;
  assign join_fire = !empty_a && !empty_b && (!out_valid || out_ready);
  assign out_fire  = out_valid && out_ready;

  vd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .count(beat_count),
    .in_fire(fork_fire), .out_fire(out_fire),
    .busy(busy), .accepting(accepting), .done(done)
  );

  vd_lane_map #(.LANES(LANES), .MODE(MAP_ENTRY)) u_entry (
    .din(in_data), .dout(tripled)
  );

  vd_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo_a (
    .clk(clk), .rst_n(rst_n), .push(fork_fire), .din(tripled), .full(full_a),
    .pop(join_fire), .dout(head_a), .empty(empty_a), .level(lvl_a)
  );

  vd_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo_b (
    .clk(clk), .rst_n(rst_n), .push(fork_fire), .din(tripled), .full(full_b),
    .pop(join_fire), .dout(head_b), .empty(empty_b), .level(lvl_b)
  );

  vd_lane_map #(.LANES(LANES), .MODE(MAP_OFFSET)) u_offset (
    .din(head_a), .dout(br_a)
  );

  vd_lane_map #(.LANES(LANES), .MODE(MAP_SCALE)) u_scale (
    .din(head_b), .dout(br_b)
  );

  vd_lane_join #(.LANES(LANES)) u_join (
    .a(br_a), .b(br_b), .sum(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (join_fire) begin
      out_valid <= 1'b1;
      out_data  <= merged;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_diamond_chk.sv
module vec_diamond_chk #(
  parameter int DW    = 512,
  parameter int CNT_W = 16,
  parameter int DEPTH = 2,
  parameter int LVW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] beat_count,
  input logic             busy,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             done,
  input logic [LVW-1:0]   lvl_a,
  input logic [LVW-1:0]   lvl_b
);
  // R4: no input is taken while idle
  a_r4_idle_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  // R7: output holds under backpressure
  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: branches stay in lockstep
  a_r8_branch_levels_equal: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_a == lvl_b);

  // R8: no FIFO overflow
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_a <= LVW'(DEPTH));

  // R6, R10: done follows a final handshake or an empty start
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(out_valid && out_ready) ||
                     $past(start && !busy && beat_count == '0)));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: busy is low while done is high
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind vec_diamond vec_diamond_chk #(
  .DW(DW), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .LVW(LVW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .beat_count(beat_count),
  .busy(busy), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done),
  .lvl_a(lvl_a), .lvl_b(lvl_b)
);

// File: tb/vec_diamond_tb.sv
module vec_diamond_tb;
  localparam int LANES = 16;
  localparam int LW    = 32;
  localparam int CNT_W = 16;
  localparam int DW    = LANES * LW;
  localparam int NT    = 8;

  // Stimulus lane value and expected lane result (9x+25 mod 2^32)
  localparam logic [31:0] T_IN [NT] = '{32'h0, 32'h1, 32'h2, 32'd100,
    32'hFFFFFFFF, 32'h1C71C71C, 32'h80000000, 32'h12345678};
  localparam logic [31:0] T_EXP[NT] = '{32'h19, 32'h22, 32'h2B, 32'h39D,
    32'h10, 32'h15, 32'h80000019, 32'hA3D70A51};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] beat_count = '0;
  logic             in_valid = 1'b0;
  logic [DW-1:0]    in_data = '0;
  logic             out_ready = 1'b0;
  logic             in_ready, out_valid, busy, done;
  logic [DW-1:0]    out_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_diamond u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_count(beat_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done)
  );

  function automatic logic [31:0] ref_lane(logic [31:0] x);
    return (x << 3) + x + 32'd25;
  endfunction

  function automatic logic [DW-1:0] splat(logic [31:0] x);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LW +: LW] = x;
    return r;
  endfunction

  function automatic logic [DW-1:0] mixed_beat(int k);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*LW +: LW] = 32'(k + 1) * 32'h9E3779B9 + 32'(i) * 32'h01000193;
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_beat(logic [DW-1:0] b);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LW +: LW] = ref_lane(b[i*LW +: LW]);
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode 0: table beats, no stall; mode 1: mixed lanes, periodic stall
  task automatic run_job(int n, int mode, bit poke_start);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    int starve = 0;
    bit holding = 0;
    logic [DW-1:0] held = '0;
    @(negedge clk);
    beat_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (got < n && cyc < 4000) begin
      in_valid  = (sent < n);
      in_data   = (mode == 0) ? splat(T_IN[sent % NT]) : mixed_beat(sent);
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      if (poke_start && cyc == 3) begin
        start = 1'b1;
        beat_count = CNT_W'(99);
      end else begin
        start = 1'b0;
      end
      #1;
      if (holding) begin
        check("R7 held valid", DW'(out_valid), DW'(1'b1));
        check("R7 held data", out_data, held);
      end
      holding = out_valid && !out_ready;
      held    = out_data;
      if (mode == 0 && in_valid && !in_ready) starve++;
      if (out_valid && out_ready) begin
        if (mode == 0) check("R1 R2 table beat", out_data, splat(T_EXP[got % NT]));
        else           check("R3 R7 mixed beat", out_data, ref_beat(mixed_beat(got)));
        got++;
      end
      if (in_valid && in_ready) sent++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R6 done after last beat", DW'(done), DW'(1'b1));
    check("R6 busy low at done", DW'(busy), DW'(1'b0));
    check("R5 accepted count", DW'(sent), DW'(n));
    if (mode == 0) check("R8 no input stall", DW'(starve), DW'(0));
    @(negedge clk);
    check("R6 done single pulse", DW'(done), DW'(1'b0));
    for (int j = 0; j < 3; j++) begin
      in_valid = 1'b1;
      in_data = splat(32'h5);
      #1;
      check("R5 R9 extra input refused", DW'(in_ready), DW'(1'b0));
      check("R5 no extra output", DW'(out_valid), DW'(1'b0));
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", DW'(out_valid), DW'(1'b0));
    check("R11 in_ready", DW'(in_ready), DW'(1'b0));
    check("R11 done", DW'(done), DW'(1'b0));
    check("R11 busy", DW'(busy), DW'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    // R4: idle block refuses input
    in_valid = 1'b1;
    in_data = splat(32'h7);
    #1;
    check("R4 idle in_ready", DW'(in_ready), DW'(1'b0));
    in_valid = 1'b0;

    run_job(NT, 0, 1'b0);       // R1 R2 R8 table walk
    run_job(2 * NT + 3, 0, 1'b0); // R8 longer sustained run
    run_job(5, 1, 1'b1);          // R3 R7 R9 stalls and ignored start

    // R10: zero-length job
    @(negedge clk);
    beat_count = '0;
    start = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R10 done on empty job", DW'(done), DW'(1'b1));
    check("R10 no input taken", DW'(in_ready), DW'(1'b0));
    check("R10 busy low", DW'(busy), DW'(1'b0));
    in_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule